// File: doc/BRIEF.md
# NRZI Bit Receiver with Adaptive Timing

This block turns a stream of line symbols (J, K, SE0, SE1) into decoded data bits. The line-state logic upstream supplies the current symbol every clock tick, a strobe on ticks where it saw the line change, and a start strobe on the J-to-K transition that opens a packet. The receiver then samples the line once per bit, near the middle of each bit. A sample equal to the one before it is a 1. A sample that differs is a 0.

The bit period is not a fixed integer count. It is a fixed-point quantity that starts from a nominal tick count. On every decoded 0 it moves by about a tenth of a percent, so the receiver follows a sender whose clock is slightly fast or slow. The direction comes from comparing the symbol reported at the last edge with the symbol sampled in the middle of the bit. A stuffed zero after six ones is removed from the output, and a one in that slot is reported as a stuffing error.

A sampled SE0 ends the data phase. The receiver then checks the rest of the end-of-packet pattern and waits for an idle J line before it accepts another start.

Top module: `nrzi_rx`

## Requirements
- R1: During and after reset every output strobe is low. The receiver first waits for the line to show J, and ignores any start strobe until it has done so.
- R2: The line symbol is coded 2'b00 = SE0, 2'b01 = J, 2'b10 = K, 2'b11 = SE1. A sample equal to the previous sample decodes as 1, a different one as 0. The first sample of a packet is compared against J.
- R3: The first sample is taken P/2 ticks after the tick that carries the start strobe (P is the nominal period). `bitValid` is seen on the tick after that sample, and the second sample follows P ticks after the first.
- R4: On a decoded 0 whose edge symbol matches the sampled symbol, the bit period shrinks by about 0.1 %. During a long run of such zeros, sample spacing never exceeds P and at some point drops to P-1.
- R5: On a decoded 0 whose edge symbol is J or K but differs from the sampled symbol, the bit period grows by about 0.1 % and the next sample moves later by about 1 % of a bit. Sample spacing never drops below P and at some point reaches P+1.
- R6: An edge that reports SE0 or SE1 leaves period and phase unchanged. If every data edge reports SE1, the spacing stays exactly P.
- R7: After six consecutive decoded 1s, a following 0 is dropped and is not presented on `bitOut`. Any decoded 0 clears the run of ones.
- R8: A 1 in the stuffed-bit slot pulses `stuffErr` for one tick and is not delivered. The run of ones restarts at zero.
- R9: Sampling SE0 during data pulses `eopStart` once, and that sample delivers no bit.
- R10: The two samples after the first SE0 must be SE0 and then J. Otherwise `eopErr` pulses once. A correct end raises no error.
- R11: After an end of packet, whether correct or failed, a start strobe is ignored until the line shows J. After that, a new packet decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineSym | input | 2 | Current line symbol (coding in R2) |
| edgeStb | input | 1 | Line changed on this tick |
| nomPeriod | input | PER_W | Nominal bit period in ticks |
| sopStb | input | 1 | Start-of-packet (J-to-K) strobe |
| bitOut | output | 1 | Decoded data bit |
| bitValid | output | 1 | `bitOut` holds a new bit |
| eopStart | output | 1 | SE0 sampled, end of packet begins |
| eopErr | output | 1 | End-of-packet pattern broken |
| stuffErr | output | 1 | Stuffing rule violated |

## Verification
A single sample can do two jobs at once. When it decodes the stuffed zero after six ones, the receiver must drop that bit and also, because it is a 0 with a J/K edge, adjust the period. The stuffing scenario provokes this by sending a run of ones long enough to force a stuffed zero in the middle of the data. It is judged by two checks: the delivered bit sequence must equal the unstuffed data, and every later bit must still decode correctly. A phase error caused by a wrong adjustment on the dropped bit would show up as corrupted bits. The timing scenarios judge the adjustments through the spacing between `bitValid` strobes.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } lineSym_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic load;    // start a packet: nominal period, half-bit phase
    logic stop;    // stop sampling
    logic shrink;  // shorten the period
    logic grow;    // lengthen the period and push the sample later
  } timeCtl_t;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_IDLE = 3'd1,
    ST_DATA = 3'd2,
    ST_EOP1 = 3'd3,
    ST_EOP2 = 3'd4
  } rxState_t;

endpackage

// File: rtl/nrzi_rx_timing.sv
module nrzi_rx_timing
  import nrzi_rx_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int FRAC_W      = 10,
  parameter int ADJ_SHIFT   = 10,  // period step = period >> ADJ_SHIFT (~0.1 %)
  parameter int PHASE_MUL   = 41,  // phase bump = period * 41 / 4096 (~1 %)
  parameter int PHASE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] nomPeriod,
  input  logic             edgeStb,
  input  lineSym_t         lineSym,
  input  timeCtl_t         ctl,
  output logic             sampleStb,
  output lineSym_t         edgeSym
);

  localparam int ACC_W = PER_W + FRAC_W + 2;
  localparam int MUL_W = ACC_W + 7;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] periodQ, phaseQ;
  logic [ACC_W-1:0] periodD, phaseD;
  logic [ACC_W-1:0] stepAmt, bumpAmt, nomFix;
  logic [MUL_W-1:0] bumpProd;
  logic             activeQ;
  lineSym_t         edgeSymQ;

  assign sampleStb = activeQ && (phaseQ <= ONE);
  assign edgeSym   = edgeSymQ;

  always_comb begin
    nomFix   = ACC_W'(nomPeriod) << FRAC_W;
    stepAmt  = periodQ >> ADJ_SHIFT;
    bumpProd = MUL_W'(periodQ) * MUL_W'(PHASE_MUL);
    bumpAmt  = ACC_W'(bumpProd >> PHASE_SHIFT);

    periodD = periodQ;
    if (ctl.grow)
      periodD = periodQ + stepAmt;
    else if (ctl.shrink)
      periodD = periodQ - stepAmt;

    phaseD = phaseQ;
    if (sampleStb)
      phaseD = phaseQ - ONE + periodD + (ctl.grow ? bumpAmt : '0);
    else if (activeQ)
      phaseD = phaseQ - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodQ  <= '0;
      phaseQ   <= '0;
      activeQ  <= 1'b0;
      edgeSymQ <= SYM_J;
    end else begin
      if (edgeStb)
        edgeSymQ <= lineSym;
      if (ctl.load) begin
        periodQ <= nomFix;
        phaseQ  <= nomFix >> 1;
        activeQ <= 1'b1;
      end else if (ctl.stop) begin
        activeQ <= 1'b0;
      end else begin
        periodQ <= periodD;
        phaseQ  <= phaseD;
      end
    end
  end

  // R4: a shrink request shortens the stored period
  p_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.shrink && !ctl.grow && !ctl.load && !ctl.stop && periodQ >= (ONE << 1))
      |=> periodQ < $past(periodQ));

  // R5: a grow request lengthens the stored period
  p_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.grow && !ctl.load && !ctl.stop && periodQ >= (ONE << 1))
      |=> periodQ > $past(periodQ));

  // R3: samples never fall on adjacent ticks for periods of two or more
  p_sample_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && nomPeriod >= PER_W'(2) && !ctl.stop) |=> !sampleStb);

endmodule

// File: rtl/nrzi_rx_ctrl.sv
module nrzi_rx_ctrl
  import nrzi_rx_pkg::*;
#(
  parameter int ONES_MAX = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sopStb,
  input  lineSym_t lineSym,
  input  logic     sampleStb,
  input  lineSym_t edgeSym,
  output timeCtl_t ctl,
  output logic     bitOut,
  output logic     bitValid,
  output logic     eopStart,
  output logic     eopErr,
  output logic     stuffErr
);

  localparam int ONES_W = $clog2(ONES_MAX + 1);

  rxState_t          stateQ, stateD;
  lineSym_t          prevQ, prevD;
  logic [ONES_W-1:0] onesQ, onesD;
  logic              bitQ, bitD, validD, eopSD, eopED, stuffED;
  logic              isZero, edgeUsable;

  always_comb begin
    ctl        = '0;
    stateD     = stateQ;
    prevD      = prevQ;
    onesD      = onesQ;
    bitD       = bitQ;
    validD     = 1'b0;
    eopSD      = 1'b0;
    eopED      = 1'b0;
    stuffED    = 1'b0;
    isZero     = (lineSym != prevQ);
    edgeUsable = (edgeSym == SYM_J) || (edgeSym == SYM_K);

    unique case (stateQ)
      ST_WAIT: begin
        if (lineSym == SYM_J) stateD = ST_IDLE;
      end
      ST_IDLE: begin
        if (sopStb) begin
          ctl.load = 1'b1;
          stateD   = ST_DATA;
          prevD    = SYM_J;
          onesD    = '0;
        end
      end
      ST_DATA: begin
        if (sampleStb) begin
          if (lineSym == SYM_SE0) begin
            eopSD  = 1'b1;
            stateD = ST_EOP1;
          end else begin
            prevD = lineSym;
            if (isZero) begin
              onesD = '0;
              if (onesQ != ONES_W'(ONES_MAX)) begin
                validD = 1'b1;
                bitD   = 1'b0;
              end
              if (edgeUsable) begin
                if (edgeSym == lineSym) ctl.shrink = 1'b1;
                else                    ctl.grow   = 1'b1;
              end
            end else if (onesQ == ONES_W'(ONES_MAX)) begin
              stuffED = 1'b1;
              onesD   = '0;
            end else begin
              validD = 1'b1;
              bitD   = 1'b1;
              onesD  = onesQ + ONES_W'(1);
            end
          end
        end
      end
      ST_EOP1: begin
        if (sampleStb) begin
          if (lineSym == SYM_SE0) begin
            stateD = ST_EOP2;
          end else begin
            eopED    = 1'b1;
            ctl.stop = 1'b1;
            stateD   = ST_WAIT;
          end
        end
      end
      ST_EOP2: begin
        if (sampleStb) begin
          ctl.stop = 1'b1;
          stateD   = ST_WAIT;
          if (lineSym != SYM_J) eopED = 1'b1;
        end
      end
      default: stateD = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ   <= ST_WAIT;
      prevQ    <= SYM_J;
      onesQ    <= '0;
      bitQ     <= 1'b0;
      bitValid <= 1'b0;
      eopStart <= 1'b0;
      eopErr   <= 1'b0;
      stuffErr <= 1'b0;
    end else begin
      stateQ   <= stateD;
      prevQ    <= prevD;
      onesQ    <= onesD;
      bitQ     <= bitD;
      bitValid <= validD;
      eopStart <= eopSD;
      eopErr   <= eopED;
      stuffErr <= stuffED;
    end
  end

  assign bitOut = bitQ;

  // R6: edges that reported SE0 or SE1 never move the timing
  p_no_adjust_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && !edgeUsable) |-> !(ctl.shrink || ctl.grow));

  // R8: a stuffing error never comes with a delivered bit
  p_stuff_nobit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stuffErr |-> !bitValid);

  // R9: the end-of-packet start is a single-tick pulse without a bit
  p_eop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eopStart |-> (!bitValid ##1 !eopStart));

  // R11: a packet is only opened from the idle state
  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |-> (stateQ == ST_IDLE));

endmodule

// File: rtl/nrzi_rx.sv
module nrzi_rx
  import nrzi_rx_pkg::*;
#(
  parameter int PER_W    = 8,
  parameter int FRAC_W   = 10,
  parameter int ONES_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lineSym,
  input  logic             edgeStb,
  input  logic [PER_W-1:0] nomPeriod,
  input  logic             sopStb,
  output logic             bitOut,
  output logic             bitValid,
  output logic             eopStart,
  output logic             eopErr,
  output logic             stuffErr
);

  lineSym_t symIn, edgeSym;
  timeCtl_t ctl;
  logic     sampleStb;

  assign symIn = lineSym_t'(lineSym);

  nrzi_rx_timing #(
    .PER_W  (PER_W),
    .FRAC_W (FRAC_W)
  ) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .nomPeriod (nomPeriod),
    .edgeStb   (edgeStb),
    .lineSym   (symIn),
    .ctl       (ctl),
    .sampleStb (sampleStb),
    .edgeSym   (edgeSym)
  );

  nrzi_rx_ctrl #(
    .ONES_MAX (ONES_MAX)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sopStb    (sopStb),
    .lineSym   (symIn),
    .sampleStb (sampleStb),
    .edgeSym   (edgeSym),
    .ctl       (ctl),
    .bitOut    (bitOut),
    .bitValid  (bitValid),
    .eopStart  (eopStart),
    .eopErr    (eopErr),
    .stuffErr  (stuffErr)
  );

endmodule

// File: tb/nrzi_rx_bench.sv
`timescale 1ns/1ps
module nrzi_rx_bench;

  localparam int P = 8;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] lineSym = K;
  logic edgeStb = 1'b0, sopStb = 1'b0;
  logic [7:0] nomPeriod = 8'(P);
  logic bitOut, bitValid, eopStart, eopErr, stuffErr;

  always #2.5 clk = ~clk;

  nrzi_rx u_nrzi_rx (
    .clk(clk), .rst_n(rst_n), .lineSym(lineSym), .edgeStb(edgeStb),
    .nomPeriod(nomPeriod), .sopStb(sopStb), .bitOut(bitOut),
    .bitValid(bitValid), .eopStart(eopStart), .eopErr(eopErr),
    .stuffErr(stuffErr)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int sopCyc = 0;
  bit gotBits[$];
  int gotTimes[$];
  bit expBits[$];
  int eopStartCnt = 0, eopErrCnt = 0, stuffErrCnt = 0;

  logic [1:0] tx [0:255];
  int txMode [0:255];  // 0 strobe at change, 1 strobe one tick early, 2 SE1 glitch
  int txN = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bitValid) begin
        gotBits.push_back(bitOut);
        gotTimes.push_back(cyc);
      end
      if (eopStart) eopStartCnt++;
      if (eopErr)   eopErrCnt++;
      if (stuffErr) stuffErrCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearRec();
    gotBits.delete();
    gotTimes.delete();
    expBits.delete();
    eopStartCnt = 0; eopErrCnt = 0; stuffErrCnt = 0;
    txN = 0;
  endtask

  task automatic addSym(input logic [1:0] s, input int m);
    tx[txN] = s;
    txMode[txN] = m;
    txN++;
  endtask

  // eopKind 0: SE0 SE0 J idle; 1: SE0 then K held
  task automatic buildPacket(input logic [63:0] d, input int n, input bit stuff,
                             input int mode, input int eopKind);
    logic [1:0] cur;
    int ones;
    cur = J;
    for (int i = 0; i < 8; i++) begin
      if (i != 7) cur = cur ^ 2'b11;
      addSym(cur, 0);
      expBits.push_back(i == 7);
    end
    ones = 1;
    for (int i = 0; i < n; i++) begin
      if (d[i]) ones++; else begin ones = 0; cur = cur ^ 2'b11; end
      addSym(cur, mode);
      expBits.push_back(d[i]);
      if (stuff && ones == 6) begin
        cur = cur ^ 2'b11;
        addSym(cur, mode);
        ones = 0;
      end
    end
    if (eopKind == 0) begin
      addSym(SE0, 0); addSym(SE0, 0);
      for (int i = 0; i < 3; i++) addSym(J, 0);
    end else begin
      addSym(SE0, 0);
      for (int i = 0; i < 3; i++) addSym(K, 0);
    end
  endtask

  task automatic play();
    bit chg;
    for (int k = 0; k < txN; k++) begin
      for (int i = 0; i < P; i++) begin
        @(negedge clk);
        chg = (k == 0) ? 1'b1 : (tx[k] != tx[k-1]);
        lineSym = tx[k];
        edgeStb = 1'b0;
        sopStb  = (k == 0 && i == 0);
        if (k == 0 && i == 0) sopCyc = cyc;
        if (i == 0 && chg && txMode[k] == 0) edgeStb = 1'b1;
        if (i == 0 && chg && txMode[k] == 2) begin lineSym = SE1; edgeStb = 1'b1; end
        if (i == P-1 && k + 1 < txN && tx[k+1] != tx[k] && txMode[k+1] == 1)
          edgeStb = 1'b1;
      end
    end
    @(negedge clk);
    edgeStb = 1'b0;
    sopStb  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmpBits(input string req);
    bit same;
    same = (gotBits.size() == expBits.size());
    if (same) foreach (expBits[i]) if (gotBits[i] != expBits[i]) same = 1'b0;
    check(same, req, "decoded bits (count shown)", gotBits.size(), expBits.size());
  endtask

  function automatic int gapCount(input int g);
    int c = 0;
    for (int i = 1; i < gotTimes.size(); i++)
      if (gotTimes[i] - gotTimes[i-1] == g) c++;
    return c;
  endfunction

  function automatic int gapMin();
    int m = 1000;
    for (int i = 1; i < gotTimes.size(); i++)
      if (gotTimes[i] - gotTimes[i-1] < m) m = gotTimes[i] - gotTimes[i-1];
    return m;
  endfunction

  function automatic int gapMax();
    int m = 0;
    for (int i = 1; i < gotTimes.size(); i++)
      if (gotTimes[i] - gotTimes[i-1] > m) m = gotTimes[i] - gotTimes[i-1];
    return m;
  endfunction

  task automatic testReset();
    repeat (3) @(negedge clk);
    check({bitValid, eopStart, eopErr, stuffErr} == 4'b0, "R1",
          "strobes in reset", {bitValid, eopStart, eopErr, stuffErr}, 0);
    rst_n = 1'b1;
    clearRec();
    @(negedge clk);
    sopStb = 1'b1; edgeStb = 1'b1; lineSym = K;
    @(negedge clk);
    sopStb = 1'b0; edgeStb = 1'b0;
    repeat (4 * P) @(negedge clk);
    check(gotBits.size() == 0, "R1", "bits before idle J", gotBits.size(), 0);
    lineSym = J;
    repeat (2 * P) @(negedge clk);
  endtask

  task automatic testBasic();
    clearRec();
    buildPacket(64'h0000_0000_0000_9649, 16, 1'b1, 0, 0);
    play();
    cmpBits("R2");
    check(gotTimes.size() > 1 && gotTimes[0] == sopCyc + 1 + P/2, "R3",
          "first sample tick", gotTimes.size() > 0 ? gotTimes[0] : -1, sopCyc + 1 + P/2);
    check(gotTimes.size() > 1 && gotTimes[1] - gotTimes[0] == P, "R3",
          "second sample spacing", gotTimes.size() > 1 ? gotTimes[1] - gotTimes[0] : -1, P);
    check(eopStartCnt == 1, "R9", "eopStart pulses", eopStartCnt, 1);
    check(eopErrCnt == 0, "R10", "eopErr on good end", eopErrCnt, 0);
  endtask

  task automatic testStuff();
    clearRec();
    buildPacket(64'h0000_0000_0000_0BFF, 16, 1'b1, 0, 0);
    play();
    cmpBits("R7");
    check(stuffErrCnt == 0, "R7", "stuffErr on legal stuffing", stuffErrCnt, 0);
  endtask

  task automatic testStuffErr();
    clearRec();
    buildPacket(64'h0000_0000_0000_00FF, 8, 1'b0, 0, 0);
    void'(expBits.pop_back());  // the sixth data one is withheld
    play();
    check(stuffErrCnt == 1, "R8", "stuffErr pulses", stuffErrCnt, 1);
    cmpBits("R8");
  endtask

  task automatic testShrink();
    clearRec();
    buildPacket(64'h0, 12, 1'b1, 0, 0);
    play();
    cmpBits("R4");
    check(gapMax() <= P, "R4", "largest spacing", gapMax(), P);
    check(gapCount(P - 1) > 0, "R4", "spacings of P-1", gapCount(P - 1), 1);
  endtask

  task automatic testGrow();
    clearRec();
    buildPacket(64'h0, 12, 1'b1, 1, 0);
    play();
    cmpBits("R5");
    check(gapMin() >= P, "R5", "smallest spacing", gapMin(), P);
    check(gapCount(P + 1) > 0, "R5", "spacings of P+1", gapCount(P + 1), 1);
  endtask

  task automatic testSe1Edge();
    clearRec();
    buildPacket(64'h0, 12, 1'b1, 2, 0);
    play();
    cmpBits("R6");
    check(gapMin() == P && gapMax() == P, "R6", "spacing with SE1 edges",
          gapMax(), P);
  endtask

  task automatic testBadEop();
    clearRec();
    buildPacket(64'h0000_0000_0000_0005, 4, 1'b1, 0, 1);
    play();
    check(eopStartCnt == 1, "R9", "eopStart on bad end", eopStartCnt, 1);
    check(eopErrCnt == 1, "R10", "eopErr on SE0 then K", eopErrCnt, 1);
    cmpBits("R10");
    gotBits.delete();
    @(negedge clk);
    sopStb = 1'b1; edgeStb = 1'b1; lineSym = K;
    @(negedge clk);
    sopStb = 1'b0; edgeStb = 1'b0;
    repeat (5 * P) @(negedge clk);
    check(gotBits.size() == 0, "R11", "bits after start while not idle",
          gotBits.size(), 0);
    lineSym = J;
    repeat (2 * P) @(negedge clk);
    clearRec();
    buildPacket(64'h0000_0000_0000_00A6, 8, 1'b1, 0, 0);
    play();
    cmpBits("R11");
  endtask

  initial begin
    testReset();
    testBasic();
    testStuff();
    testStuffErr();
    testShrink();
    testGrow();
    testSe1Edge();
    testBadEop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule